// File: doc/BRIEF.md
# Field Firmware Update Sequencer

This block runs a manual-mode firmware update on an embedded flash device from the host side. When it is started, it checks two capability bytes that the host read earlier and the requested image length. If the update is allowed, it sets the block length and switches the device into update mode. It then streams the image as one multi-block write, stops the write and leaves update mode. Next it holds the device's hardware reset line low, lets the device recover, and brings the device back up with a go-idle command and an operating-condition command. Finally it reads the 512-byte extended register and keeps the byte at offset 26, which carries the update result.

Commands go out through a simple command port: an index, an argument and a valid strobe that stays high until the device side returns a completion, which may carry an error flag. Sector payloads are requested one sector at a time on a request/acknowledge pair. The extended-register bytes come back on a byte strobe. The block finishes with a one-cycle done pulse, a pass flag, a result code and the raw status byte. All of these outputs hold until the next run.

Top module: `fwupd_seq`

## Requirements
- R1: On an allowed run the commands are issued in this order: index 16 arg 0x00000200; index 6 arg 0x031E0100; index 25 arg 0x00000000; the sector payloads; index 12 arg 0x00000000; index 6 arg 0x031E0000; the hardware reset; index 0 arg 0x00000000; index 1 arg OCR_ARG (default 0x40FF8080); index 8 arg 0x00000000.
- R2: While `cmd_valid` is high and `cmd_done` is low, the valid strobe, the index and the argument stay unchanged on the next cycle.
- R3: Between the completion of index 25 and the issue of index 12, exactly `sector_count` sector requests are acknowledged. No command is valid while a sector is requested.
- R4: After the completion of the update-exit command, `dev_rst_n` is low for exactly RST_LEN cycles and then high for at least RECOV_LEN cycles before index 0 is issued. No command is valid while `dev_rst_n` is low.
- R5: A start is refused when bit 0 of `cap_modes` is 0, when bit 0 of `cap_fwcfg` is 1, or when `sector_count` is 0. A refused start issues no command, pulses `done`, and reports result 3 with status 0xFF.
- R6: The status byte is the byte at offset 26 (counting from 0) of the 512 bytes received after index 8 completes.
- R7: Result codes: status 0x00 gives result 0 with pass=1. Status 0x10, 0x11 or 0x12 gives result 1. Any other status gives result 2. Results 1 and 2 have pass=0.
- R8: A completion with the error flag aborts the run with result 4, pass=0 and status 0xFF. If the error hits a command after update mode was entered (index 25, index 12), the update-exit command is issued first. An error on the entry command, on the exit command, or on any command after the reset aborts at once.
- R9: No single- or multi-block read command (index 17 or 18) is valid while update mode is active.
- R10: `done` is high for exactly one cycle per run, the results hold until the next run, and a start while a run is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken only when idle |
| cap_modes | input | 8 | Supported-modes byte; bit 0 = update supported |
| cap_fwcfg | input | 8 | Firmware-config byte; bit 0 = updates disabled |
| sector_count | input | SEC_W | Image length in 512-byte sectors |
| cmd_valid | output | 1 | Command request |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_done | input | 1 | Command completed (response received) |
| cmd_err | input | 1 | Error flag, valid with cmd_done |
| blk_req | output | 1 | Request for one image sector |
| blk_ack | input | 1 | Sector sent |
| dev_rst_n | output | 1 | Device hardware reset, active low |
| rd_valid | input | 1 | Extended-register byte strobe |
| rd_byte | input | 8 | Extended-register byte |
| done | output | 1 | End-of-run pulse |
| pass | output | 1 | Update succeeded |
| res_code | output | 3 | 0 ok, 1 device error, 2 reserved status, 3 refused, 4 aborted |
| status | output | 8 | Raw status byte, 0xFF if never read |

## Verification
The assertions check on every cycle that a pending command stays stable, that no read command appears while update mode is active, and that no command overlaps the reset pulse or a sector request. They also check that done is a single pulse and that a success result always carries a zero status. The order of the command list, the exact reset length and recovery gap, the sector count, the offset of the captured byte, the full decode table and each abort path depend on the whole run. Only the bench scenarios can show them, by comparing the logged traffic and the results against a model of the expected sequence.

// File: rtl/fwupd_pkg.sv
package fwupd_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_XFER,
        PH_RST,
        PH_RDX
    } phase_e;

    typedef enum logic [2:0] {
        SP_BLKLEN,
        SP_ENTER,
        SP_WRITE,
        SP_STOP,
        SP_EXIT,
        SP_GOIDLE,
        SP_OPCOND,
        SP_READX
    } step_e;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_FWERR   = 3'd1,
        RES_RSVD    = 3'd2,
        RES_REFUSED = 3'd3,
        RES_ABORT   = 3'd4
    } res_e;

    typedef struct packed {
        logic [5:0]  idx;
        logic [31:0] arg;
    } cmd_t;

    localparam logic [31:0] ARG_ZERO    = 32'h0000_0000;
    localparam logic [31:0] ARG_BLK512  = 32'h0000_0200;
    localparam logic [31:0] ARG_FFU_ON  = 32'h031E_0100;
    localparam logic [31:0] ARG_FFU_OFF = 32'h031E_0000;

    localparam logic [7:0] STAT_PASS = 8'h00;
    localparam logic [7:0] STAT_GEN  = 8'h10;
    localparam logic [7:0] STAT_INST = 8'h11;
    localparam logic [7:0] STAT_DL   = 8'h12;
    localparam logic [7:0] STAT_NONE = 8'hFF;

    function automatic res_e decode_status(input logic [7:0] s);
        if (s == STAT_PASS)
            return RES_OK;
        else if (s == STAT_GEN || s == STAT_INST || s == STAT_DL)
            return RES_FWERR;
        else
            return RES_RSVD;
    endfunction

endpackage

// File: rtl/fwupd_step_rom.sv
module fwupd_step_rom
    import fwupd_pkg::*;
#(
    parameter logic [31:0] OCR_ARG = 32'h40FF_8080
) (
    input  step_e step,
    output cmd_t  cmd
);
    always_comb begin
        unique case (step)
            SP_BLKLEN: cmd = '{idx: 6'd16, arg: ARG_BLK512};
            SP_ENTER:  cmd = '{idx: 6'd6,  arg: ARG_FFU_ON};
            SP_WRITE:  cmd = '{idx: 6'd25, arg: ARG_ZERO};
            SP_STOP:   cmd = '{idx: 6'd12, arg: ARG_ZERO};
            SP_EXIT:   cmd = '{idx: 6'd6,  arg: ARG_FFU_OFF};
            SP_GOIDLE: cmd = '{idx: 6'd0,  arg: ARG_ZERO};
            SP_OPCOND: cmd = '{idx: 6'd1,  arg: OCR_ARG};
            SP_READX:  cmd = '{idx: 6'd8,  arg: ARG_ZERO};
            default:   cmd = '{idx: 6'd0,  arg: ARG_ZERO};
        endcase
    end
endmodule

// File: rtl/fwupd_rst_gen.sv
module fwupd_rst_gen #(
    parameter int RST_LEN   = 8,
    parameter int RECOV_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic dev_rst_n,
    output logic fin
);
    localparam int TOT = RST_LEN + RECOV_LEN;
    localparam int CW  = $clog2(TOT + 1);

    logic [CW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (go && !run) begin
            run <= 1'b1;
            cnt <= '0;
        end else if (run) begin
            if (cnt == CW'(TOT - 1))
                run <= 1'b0;
            cnt <= cnt + 1'b1;
        end
    end

    assign dev_rst_n = !(run && (cnt < CW'(RST_LEN)));
    assign fin       = run && (cnt == CW'(TOT - 1));

    assert_low_only_running_R4: assert property (@(posedge clk) disable iff (rst)
        !dev_rst_n |-> run);
endmodule

// File: rtl/fwupd_stat_cap.sv
module fwupd_stat_cap
    import fwupd_pkg::*;
#(
    parameter int NBYTES = 512,
    parameter int OFS    = 26
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       en,
    input  logic       rd_valid,
    input  logic [7:0] rd_byte,
    output logic [7:0] stat,
    output logic       last
);
    localparam int CW = $clog2(NBYTES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt  <= '0;
            stat <= STAT_NONE;
        end else if (en && rd_valid) begin
            if (cnt == CW'(OFS))
                stat <= rd_byte;
            cnt <= cnt + 1'b1;
        end
    end

    assign last = en && rd_valid && (cnt == CW'(NBYTES - 1));

    assert_hold_after_ofs_R6: assert property (@(posedge clk) disable iff (rst || clr)
        (en && rd_valid && cnt > CW'(OFS)) |=> $stable(stat));
endmodule

// File: rtl/fwupd_seq.sv
module fwupd_seq
    import fwupd_pkg::*;
#(
    parameter int          SEC_W     = 16,
    parameter int          RST_LEN   = 8,
    parameter int          RECOV_LEN = 16,
    parameter int          XREG_LEN  = 512,
    parameter int          STAT_OFS  = 26,
    parameter logic [31:0] OCR_ARG   = 32'h40FF_8080
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [7:0]       cap_modes,
    input  logic [7:0]       cap_fwcfg,
    input  logic [SEC_W-1:0] sector_count,
    output logic             cmd_valid,
    output logic [5:0]       cmd_index,
    output logic [31:0]      cmd_arg,
    input  logic             cmd_done,
    input  logic             cmd_err,
    output logic             blk_req,
    input  logic             blk_ack,
    output logic             dev_rst_n,
    input  logic             rd_valid,
    input  logic [7:0]       rd_byte,
    output logic             done,
    output logic             pass,
    output logic [2:0]       res_code,
    output logic [7:0]       status
);
    phase_e           ph;
    step_e            step;
    logic [SEC_W-1:0] sec_left;
    logic             ffu_on;
    logic             abort_q;
    logic             done_q;
    logic             pass_q;
    res_e             res_q;
    logic [7:0]       stat_q;

    cmd_t             cur_cmd;
    logic             rst_go;
    logic             rst_fin;
    logic [7:0]       cap_stat;
    logic             cap_last;
    logic             ok_cfg;
    logic             unused_bits;

    assign unused_bits = ^{cap_modes[7:1], cap_fwcfg[7:1]};
    assign ok_cfg = cap_modes[0] && !cap_fwcfg[0] && (sector_count != '0);

    fwupd_step_rom #(.OCR_ARG(OCR_ARG)) u_rom (
        .step (step),
        .cmd  (cur_cmd)
    );

    assign rst_go = (ph == PH_CMD) && (step == SP_EXIT) && cmd_done
                    && !cmd_err && !abort_q;

    fwupd_rst_gen #(.RST_LEN(RST_LEN), .RECOV_LEN(RECOV_LEN)) u_rst (
        .clk       (clk),
        .rst       (rst),
        .go        (rst_go),
        .dev_rst_n (dev_rst_n),
        .fin       (rst_fin)
    );

    fwupd_stat_cap #(.NBYTES(XREG_LEN), .OFS(STAT_OFS)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .clr      (start && ph == PH_IDLE),
        .en       (ph == PH_RDX),
        .rd_valid (rd_valid),
        .rd_byte  (rd_byte),
        .stat     (cap_stat),
        .last     (cap_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            step     <= SP_BLKLEN;
            sec_left <= '0;
            ffu_on   <= 1'b0;
            abort_q  <= 1'b0;
            done_q   <= 1'b0;
            pass_q   <= 1'b0;
            res_q    <= RES_ABORT;
            stat_q   <= STAT_NONE;
        end else begin
            done_q <= 1'b0;
            unique case (ph)
                PH_IDLE: begin
                    if (start) begin
                        if (ok_cfg) begin
                            ph       <= PH_CMD;
                            step     <= SP_BLKLEN;
                            sec_left <= sector_count;
                            abort_q  <= 1'b0;
                        end else begin
                            done_q <= 1'b1;
                            pass_q <= 1'b0;
                            res_q  <= RES_REFUSED;
                            stat_q <= STAT_NONE;
                        end
                    end
                end
                PH_CMD: begin
                    if (cmd_done) begin
                        if (step == SP_EXIT) begin
                            ffu_on <= 1'b0;
                            if (abort_q || cmd_err) begin
                                ph      <= PH_IDLE;
                                abort_q <= 1'b0;
                                done_q  <= 1'b1;
                                pass_q  <= 1'b0;
                                res_q   <= RES_ABORT;
                                stat_q  <= STAT_NONE;
                            end else begin
                                ph <= PH_RST;
                            end
                        end else if (cmd_err) begin
                            if (ffu_on) begin
                                step    <= SP_EXIT;
                                abort_q <= 1'b1;
                            end else begin
                                ph     <= PH_IDLE;
                                done_q <= 1'b1;
                                pass_q <= 1'b0;
                                res_q  <= RES_ABORT;
                                stat_q <= STAT_NONE;
                            end
                        end else begin
                            unique case (step)
                                SP_BLKLEN: step <= SP_ENTER;
                                SP_ENTER: begin
                                    ffu_on <= 1'b1;
                                    step   <= SP_WRITE;
                                end
                                SP_WRITE:  ph   <= PH_XFER;
                                SP_STOP:   step <= SP_EXIT;
                                SP_GOIDLE: step <= SP_OPCOND;
                                SP_OPCOND: step <= SP_READX;
                                SP_READX:  ph   <= PH_RDX;
                                default:   step <= step;
                            endcase
                        end
                    end
                end
                PH_XFER: begin
                    if (blk_ack) begin
                        if (sec_left == SEC_W'(1)) begin
                            ph   <= PH_CMD;
                            step <= SP_STOP;
                        end
                        sec_left <= sec_left - 1'b1;
                    end
                end
                PH_RST: begin
                    if (rst_fin) begin
                        ph   <= PH_CMD;
                        step <= SP_GOIDLE;
                    end
                end
                PH_RDX: begin
                    if (cap_last) begin
                        ph     <= PH_IDLE;
                        done_q <= 1'b1;
                        stat_q <= cap_stat;
                        res_q  <= decode_status(cap_stat);
                        pass_q <= (decode_status(cap_stat) == RES_OK);
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign cmd_valid = (ph == PH_CMD);
    assign cmd_index = cur_cmd.idx;
    assign cmd_arg   = cur_cmd.arg;
    assign blk_req   = (ph == PH_XFER);
    assign done      = done_q;
    assign pass      = pass_q;
    assign res_code  = res_q;
    assign status    = stat_q;

    assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_index) && $stable(cmd_arg)));

    assert_xfer_in_mode_R3: assert property (@(posedge clk) disable iff (rst)
        blk_req |-> (ffu_on && !cmd_valid));

    assert_rst_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !dev_rst_n |-> (!cmd_valid && !ffu_on));

    assert_no_read_R9: assert property (@(posedge clk) disable iff (rst)
        ffu_on |-> !(cmd_valid && (cmd_index == 6'd17 || cmd_index == 6'd18)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_ok_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (done && res_code == 3'd0) |-> (status == 8'h00 && pass));
endmodule

// File: tb/fwupd_seq_tb.sv
module fwupd_seq_tb;
    localparam int          SEC_W     = 16;
    localparam int          RST_LEN   = 8;
    localparam int          RECOV_LEN = 16;
    localparam logic [31:0] OCR       = 32'h40FF_8080;
    localparam int          MK_SEC    = 100;
    localparam int          MK_RST    = 99;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic             start = 1'b0;
    logic [7:0]       cap_modes = 8'h01;
    logic [7:0]       cap_fwcfg = 8'h00;
    logic [SEC_W-1:0] sector_count = '0;
    logic             cmd_valid;
    logic [5:0]       cmd_index;
    logic [31:0]      cmd_arg;
    logic             cmd_done = 1'b0;
    logic             cmd_err = 1'b0;
    logic             blk_req;
    logic             blk_ack = 1'b0;
    logic             dev_rst_n;
    logic             rd_valid = 1'b0;
    logic [7:0]       rd_byte = 8'h00;
    logic             done;
    logic             pass;
    logic [2:0]       res_code;
    logic [7:0]       status;

    fwupd_seq #(.SEC_W(SEC_W), .RST_LEN(RST_LEN), .RECOV_LEN(RECOV_LEN), .OCR_ARG(OCR)) u_dut (
        .clk(clk), .rst(rst), .start(start), .cap_modes(cap_modes), .cap_fwcfg(cap_fwcfg),
        .sector_count(sector_count), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
        .cmd_arg(cmd_arg), .cmd_done(cmd_done), .cmd_err(cmd_err), .blk_req(blk_req),
        .blk_ack(blk_ack), .dev_rst_n(dev_rst_n), .rd_valid(rd_valid), .rd_byte(rd_byte),
        .done(done), .pass(pass), .res_code(res_code), .status(status)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    int          log_idx[$];
    logic [31:0] log_arg[$];
    int          exp_idx[$];
    logic [31:0] exp_arg[$];

    int         err_at = -1;
    int         seen = 0;
    int         wcnt = 0;
    logic       rd_on = 1'b0;
    int         rd_i = 0;
    logic [7:0] stat_val = 8'h00;
    logic       rn_prev = 1'b1;
    int         low_cnt = 0;
    int         gap_cnt = 0;
    logic       gap_on = 1'b0;

    task automatic chk(input string req, input longint act, input longint expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic summary_and_end();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // device-side responder and traffic logger
    always @(negedge clk) begin
        cmd_done <= 1'b0;
        cmd_err  <= 1'b0;
        blk_ack  <= 1'b0;
        rd_valid <= 1'b0;
        if (rst) begin
            wcnt    <= 0;
            rd_on   <= 1'b0;
            rd_i    <= 0;
            rn_prev <= 1'b1;
        end else begin
            if (cmd_valid && !cmd_done) begin
                if (wcnt == 2) begin
                    cmd_done <= 1'b1;
                    cmd_err  <= (seen == err_at);
                    seen     <= seen + 1;
                    wcnt     <= 0;
                    log_idx.push_back(int'(cmd_index));
                    log_arg.push_back(cmd_arg);
                    if (cmd_index == 6'd8 && seen != err_at) begin
                        rd_on <= 1'b1;
                        rd_i  <= 0;
                    end
                end else begin
                    wcnt <= wcnt + 1;
                end
            end
            if (blk_req && !blk_ack) begin
                blk_ack <= 1'b1;
                log_idx.push_back(MK_SEC);
                log_arg.push_back(32'h0);
            end
            if (rd_on) begin
                rd_valid <= 1'b1;
                rd_byte  <= (rd_i == 26) ? stat_val : (8'(rd_i) ^ 8'h5A);
                if (rd_i == 511) rd_on <= 1'b0;
                rd_i <= rd_i + 1;
            end
            if (rn_prev && !dev_rst_n) begin
                log_idx.push_back(MK_RST);
                log_arg.push_back(32'h0);
            end
            rn_prev <= dev_rst_n;
        end
    end

    // per-cycle behavioural checks on reset timing and forbidden traffic
    always @(negedge clk) begin
        if (!rst) begin
            if (!dev_rst_n) begin
                low_cnt = low_cnt + 1;
                chk("R4 no command during reset", longint'(cmd_valid), 0);
            end else if (low_cnt != 0) begin
                chk("R4 reset low length", low_cnt, RST_LEN);
                low_cnt = 0;
                gap_on  = 1'b1;
                gap_cnt = 0;
            end
            if (gap_on) begin
                if (cmd_valid) begin
                    chk("R4 recovery gap", longint'(gap_cnt >= RECOV_LEN), 1);
                    gap_on = 1'b0;
                end else begin
                    gap_cnt = gap_cnt + 1;
                end
            end
            if (cmd_valid && (cmd_index == 6'd17 || cmd_index == 6'd18)) begin
                chk("R9 read command issued", longint'(cmd_index), 0);
            end
            if (blk_req) chk("R3 command during sector", longint'(cmd_valid), 0);
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            summary_and_end();
        end
    end

    function automatic int exp_result(input logic [7:0] s);
        if (s == 8'h00) return 0;
        if (s == 8'h10 || s == 8'h11 || s == 8'h12) return 1;
        return 2;
    endfunction

    task automatic push_exp(input int i, input logic [31:0] a);
        exp_idx.push_back(i);
        exp_arg.push_back(a);
    endtask

    task automatic run_case(input string name, input logic [7:0] modes, input logic [7:0] cfg,
                            input int nsec, input int errpos, input logic [7:0] sv,
                            input bit refused, input bit restart_mid);
        int          f_idx[$];
        logic [31:0] f_arg[$];
        int          ncmd;
        int          want_res;
        logic [7:0]  want_stat;
        bit          got_done;

        log_idx.delete(); log_arg.delete();
        exp_idx.delete(); exp_arg.delete();

        if (!refused) begin
            f_idx = {16, 6, 25};
            f_arg = {32'h0000_0200, 32'h031E_0100, 32'h0};
            for (int k = 0; k < nsec; k++) begin f_idx.push_back(MK_SEC); f_arg.push_back(32'h0); end
            f_idx.push_back(12);     f_arg.push_back(32'h0);
            f_idx.push_back(6);      f_arg.push_back(32'h031E_0000);
            f_idx.push_back(MK_RST); f_arg.push_back(32'h0);
            f_idx.push_back(0);      f_arg.push_back(32'h0);
            f_idx.push_back(1);      f_arg.push_back(OCR);
            f_idx.push_back(8);      f_arg.push_back(32'h0);
            ncmd = 0;
            foreach (f_idx[k]) begin
                push_exp(f_idx[k], f_arg[k]);
                if (f_idx[k] < MK_RST) begin
                    if (ncmd == errpos) break;
                    ncmd++;
                end
            end
            if (errpos == 2 || errpos == 3) push_exp(6, 32'h031E_0000);
        end

        if (refused) begin
            want_res = 3; want_stat = 8'hFF;
        end else if (errpos >= 0) begin
            want_res = 4; want_stat = 8'hFF;
        end else begin
            want_res = exp_result(sv); want_stat = sv;
        end

        @(negedge clk);
        cap_modes    = modes;
        cap_fwcfg    = cfg;
        sector_count = SEC_W'(nsec);
        err_at       = errpos;
        seen         = 0;
        stat_val     = sv;
        start        = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (restart_mid) begin
            repeat (10) @(negedge clk);
            cap_modes    = 8'h00;
            sector_count = SEC_W'(nsec + 5);
            start        = 1'b1;
            @(negedge clk);
            start        = 1'b0;
        end
        got_done = done;
        for (int i = 0; i < 20000 && !got_done; i++) begin
            @(negedge clk);
            got_done = done;
        end
        chk({"R10 done seen ", name}, longint'(got_done), 1);
        chk({"R7 R8 R5 result ", name}, longint'(res_code), want_res);
        chk({"R6 status ", name}, longint'(status), longint'(want_stat));
        chk({"R7 pass ", name}, longint'(pass), longint'(want_res == 0));
        @(negedge clk);
        chk({"R10 done single ", name}, longint'(done), 0);
        repeat (30) @(negedge clk);
        chk({"R10 results held ", name}, longint'(res_code), want_res);
        chk({"R1 R3 traffic length ", name}, log_idx.size(), exp_idx.size());
        for (int k = 0; k < exp_idx.size() && k < log_idx.size(); k++) begin
            chk({"R1 index ", name}, log_idx[k], exp_idx[k]);
            chk({"R1 argument ", name}, longint'(log_arg[k]), longint'(exp_arg[k]));
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset done", longint'(done), 0);
        chk("R2 reset cmd_valid", longint'(cmd_valid), 0);
        chk("R3 reset blk_req", longint'(blk_req), 0);
        chk("R4 reset dev_rst_n", longint'(dev_rst_n), 1);
        chk("R7 reset pass", longint'(pass), 0);
        chk("R6 reset status", longint'(status), 8'hFF);

        run_case("ok3",       8'h01, 8'h00, 3, -1, 8'h00, 1'b0, 1'b0);
        run_case("inst1",     8'h03, 8'h00, 1, -1, 8'h11, 1'b0, 1'b0);
        run_case("rsvd",      8'h01, 8'h02, 2, -1, 8'h37, 1'b0, 1'b0);
        run_case("dl_busy",   8'h01, 8'h00, 2, -1, 8'h12, 1'b0, 1'b1);
        run_case("gen",       8'h01, 8'h00, 1, -1, 8'h10, 1'b0, 1'b0);
        run_case("no_sup",    8'h02, 8'h00, 3, -1, 8'h00, 1'b1, 1'b0);
        run_case("disabled",  8'h01, 8'h01, 3, -1, 8'h00, 1'b1, 1'b0);
        run_case("zero_sec",  8'h01, 8'h00, 0, -1, 8'h00, 1'b1, 1'b0);
        run_case("err_blk",   8'h01, 8'h00, 2, 0,  8'h00, 1'b0, 1'b0);
        run_case("err_enter", 8'h01, 8'h00, 2, 1,  8'h00, 1'b0, 1'b0);
        run_case("err_write", 8'h01, 8'h00, 2, 2,  8'h00, 1'b0, 1'b0);
        run_case("err_stop",  8'h01, 8'h00, 2, 3,  8'h00, 1'b0, 1'b0);
        run_case("err_exit",  8'h01, 8'h00, 2, 4,  8'h00, 1'b0, 1'b0);
        run_case("err_opc",   8'h01, 8'h00, 1, 6,  8'h00, 1'b0, 1'b0);
        run_case("err_readx", 8'h01, 8'h00, 1, 7,  8'h00, 1'b0, 1'b0);

        summary_and_end();
    end
endmodule